// File: doc/BRIEF.md
# Cascaded Device Select Gate

This block sits in each member of a chain of identical associative-memory devices that share one data bus. It keeps two registers per device: a page identifier that names this device within the chain, and a select register that names which device (or all of them) the next bus cycles address. For every bus cycle it decides whether this device takes a write, drives a read, or stays off the bus. The memory array, the compare engine and the pin tristate buffers are outside it.

Page identifiers are assigned one device at a time. A chain-enable signal passes down the chain and is high only past devices whose identifier is already loaded. A page load is taken by the first device in the chain that has not yet been loaded. When the select register holds all ones, every device takes writes together, for example to load compare data everywhere at once. In that mode a read is driven only by the device holding a match. A match-priority chain (hit in, hit out) ensures that only the first matching device drives. When the select register equals this device's own identifier, the device is addressed alone, for both reads and writes. A soft reset command clears the select register and the loaded flag, and keeps the stored identifier.

Top module: `chain_sel_gate`

## Requirements
- R1: After hardware reset (rst_n low), the identifier and select registers are 0000H and the loaded flag is clear, so chain_en_o is 0.
- R2: A page load (pa_wr) is taken only when chain_en_i is 1, the loaded flag is clear and wr_data is not all ones. The identifier then takes wr_data and the loaded flag is set at the next clock edge.
- R3: A page load whose data is all ones is refused. The identifier and the loaded flag are unchanged, so the next device in the chain is not yet enabled.
- R4: chain_en_o is 1 exactly when chain_en_i is 1 and the loaded flag is set (combinational).
- R5: ds_wr loads wr_data into the select register at the next clock edge, whatever the chain state.
- R6: With the select register all ones, a valid write cycle (cyc_valid=1, cyc_write=1) raises wr_accept_o in every device.
- R7: With the select register all ones, a valid read cycle (cyc_valid=1, cyc_write=0) raises rd_drive_o only when match_i=1 and hit_i=0. hit_o is always hit_i OR match_i.
- R8: With the select register equal to the identifier (and not all ones), valid write cycles raise wr_accept_o and valid read cycles raise rd_drive_o, whatever match_i is.
- R9: With the select register matching neither all ones nor the identifier, wr_accept_o and rd_drive_o stay 0.
- R10: ctl_reset clears the select register and the loaded flag at the next edge and leaves the identifier unchanged. It takes priority over pa_wr and ds_wr in the same cycle.
- R11: wr_accept_o is only ever high on valid write cycles and rd_drive_o only on valid read cycles. The two are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Hardware reset, active low, asynchronous |
| cyc_valid | input | 1 | A data bus cycle is in progress |
| cyc_write | input | 1 | 1 = write cycle, 0 = read cycle |
| pa_wr | input | 1 | Page identifier load strobe |
| ds_wr | input | 1 | Select register write strobe |
| wr_data | input | W | Data for pa_wr and ds_wr |
| ctl_reset | input | 1 | Soft reset command |
| match_i | input | 1 | Local match flag from the compare logic |
| chain_en_i | input | 1 | Chain enable from the upstream device (tie 1 at the head) |
| hit_i | input | 1 | Some upstream device holds a match (tie 0 at the head) |
| wr_accept_o | output | 1 | This device takes the current write |
| rd_drive_o | output | 1 | This device drives the current read |
| chain_en_o | output | 1 | Chain enable to the downstream device |
| hit_o | output | 1 | Match-priority chain to the downstream device |

## Verification
The hardest case to reach is keeping the identifier through a soft reset. The identifier is not visible at the ports. The bench therefore issues ctl_reset, including in the same cycle as a page load, and then writes the select register with each old identifier in turn. The addressed device must answer alone. A second hard case is a broadcast read with several matching devices. Four chained instances are driven with overlapping match patterns, and the bench checks each cycle that only the first matching device drives the bus. A refused all-ones load is placed between two good loads, which shows that it does not move the chain enable on.

// File: rtl/csg_pkg.sv
package csg_pkg;
  typedef enum logic [1:0] {
    SEL_NONE  = 2'd0,
    SEL_OWN   = 2'd1,
    SEL_BCAST = 2'd2
  } sel_mode_e;
endpackage

// File: rtl/csg_id_reg.sv
module csg_id_reg #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ctl_reset,
  input  logic         load_req,
  input  logic [W-1:0] load_data,
  input  logic         chain_en_i,
  output logic [W-1:0] pa_q,
  output logic         full_q,
  output logic         chain_en_o
);
  localparam logic [W-1:0] ALL1 = {W{1'b1}};

  logic load_ok;
  // the first device in the chain that is not yet loaded takes the load; all-ones is refused
  assign load_ok = load_req && chain_en_i && !full_q && (load_data != ALL1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pa_q   <= '0;
      full_q <= 1'b0;
    end else if (ctl_reset) begin
      full_q <= 1'b0;          // the identifier is kept
    end else if (load_ok) begin
      pa_q   <= load_data;
      full_q <= 1'b1;
    end
  end

  assign chain_en_o = chain_en_i && full_q;
endmodule

// File: rtl/csg_ds_reg.sv
module csg_ds_reg #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ctl_reset,
  input  logic         ds_wr,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] ds_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         ds_q <= '0;
    else if (ctl_reset) ds_q <= '0;
    else if (ds_wr)     ds_q <= wr_data;
  end
endmodule

// File: rtl/csg_decode.sv
module csg_decode
  import csg_pkg::*;
#(
  parameter int W         = 16,
  parameter bit PRIO_READ = 1'b1
) (
  input  logic [W-1:0] ds_q,
  input  logic [W-1:0] pa_q,
  input  logic         cyc_valid,
  input  logic         cyc_write,
  input  logic         match_i,
  input  logic         hit_i,
  output sel_mode_e    mode,
  output logic         wr_accept_o,
  output logic         rd_drive_o,
  output logic         hit_o
);
  localparam logic [W-1:0] ALL1 = {W{1'b1}};

  logic bcast_rd_ok;
  logic wr_cyc, rd_cyc;

  always_comb begin
    if (ds_q == ALL1)      mode = SEL_BCAST;
    else if (ds_q == pa_q) mode = SEL_OWN;
    else                   mode = SEL_NONE;
  end

  generate
    if (PRIO_READ) begin : g_prio
      // only the first matching device along the chain may drive
      assign bcast_rd_ok = match_i && !hit_i;
    end else begin : g_plain
      assign bcast_rd_ok = match_i;
    end
  endgenerate

  assign hit_o  = hit_i || match_i;
  assign wr_cyc = cyc_valid && cyc_write;
  assign rd_cyc = cyc_valid && !cyc_write;

  always_comb begin
    wr_accept_o = 1'b0;
    rd_drive_o  = 1'b0;
    unique case (mode)
      SEL_BCAST: begin
        wr_accept_o = wr_cyc;
        rd_drive_o  = rd_cyc && bcast_rd_ok;
      end
      SEL_OWN: begin
        wr_accept_o = wr_cyc;
        rd_drive_o  = rd_cyc;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/chain_sel_gate.sv
module chain_sel_gate
  import csg_pkg::*;
#(
  parameter int W         = 16,
  parameter bit PRIO_READ = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cyc_valid,
  input  logic         cyc_write,
  input  logic         pa_wr,
  input  logic         ds_wr,
  input  logic [W-1:0] wr_data,
  input  logic         ctl_reset,
  input  logic         match_i,
  input  logic         chain_en_i,
  input  logic         hit_i,
  output logic         wr_accept_o,
  output logic         rd_drive_o,
  output logic         chain_en_o,
  output logic         hit_o
);
  logic [W-1:0] pa_q;
  logic [W-1:0] ds_q;
  logic         full_q;
  sel_mode_e    mode;

  csg_id_reg #(.W(W)) u_id (
    .clk(clk), .rst_n(rst_n), .ctl_reset(ctl_reset),
    .load_req(pa_wr), .load_data(wr_data), .chain_en_i(chain_en_i),
    .pa_q(pa_q), .full_q(full_q), .chain_en_o(chain_en_o)
  );

  csg_ds_reg #(.W(W)) u_ds (
    .clk(clk), .rst_n(rst_n), .ctl_reset(ctl_reset),
    .ds_wr(ds_wr), .wr_data(wr_data), .ds_q(ds_q)
  );

  csg_decode #(.W(W), .PRIO_READ(PRIO_READ)) u_dec (
    .ds_q(ds_q), .pa_q(pa_q), .cyc_valid(cyc_valid), .cyc_write(cyc_write),
    .match_i(match_i), .hit_i(hit_i), .mode(mode),
    .wr_accept_o(wr_accept_o), .rd_drive_o(rd_drive_o), .hit_o(hit_o)
  );
endmodule

// File: rtl/csg_checker.sv
module csg_checker #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         cyc_valid,
  input logic         cyc_write,
  input logic         pa_wr,
  input logic         ctl_reset,
  input logic         match_i,
  input logic         chain_en_i,
  input logic         hit_i,
  input logic         wr_accept_o,
  input logic         rd_drive_o,
  input logic         chain_en_o,
  input logic [W-1:0] pa_q,
  input logic [W-1:0] ds_q,
  input logic         full_q
);
  localparam logic [W-1:0] ALL1 = {W{1'b1}};

  a_r2_load_source: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(full_q) |-> $past(pa_wr && chain_en_i && !ctl_reset));

  a_r3_never_all_ones: assert property (@(posedge clk) disable iff (!rst_n)
    pa_q != ALL1);

  a_r4_chain_gate: assert property (@(posedge clk) disable iff (!rst_n)
    chain_en_o |-> (chain_en_i && full_q));

  a_r6_bcast_write: assert property (@(posedge clk) disable iff (!rst_n)
    (ds_q == ALL1 && cyc_valid && cyc_write) |-> wr_accept_o);

  a_r7_bcast_read_match: assert property (@(posedge clk) disable iff (!rst_n)
    (ds_q == ALL1 && (!match_i || hit_i)) |-> !rd_drive_o);

  a_r9_unselected: assert property (@(posedge clk) disable iff (!rst_n)
    (ds_q != ALL1 && ds_q != pa_q) |-> !(wr_accept_o || rd_drive_o));

  a_r10_pa_kept: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_reset |=> $stable(pa_q));

  a_r10_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_reset |=> (ds_q == '0 && !full_q));

  a_r11_cycle_type: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_accept_o && (!cyc_valid || !cyc_write)) && !(rd_drive_o && (!cyc_valid || cyc_write)));
endmodule

bind chain_sel_gate csg_checker #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cyc_valid(cyc_valid), .cyc_write(cyc_write),
  .pa_wr(pa_wr), .ctl_reset(ctl_reset), .match_i(match_i),
  .chain_en_i(chain_en_i), .hit_i(hit_i), .wr_accept_o(wr_accept_o),
  .rd_drive_o(rd_drive_o), .chain_en_o(chain_en_o),
  .pa_q(pa_q), .ds_q(ds_q), .full_q(full_q)
);

// File: tb/sim_chain_sel_gate.sv
`timescale 1ns/1ps
module sim_chain_sel_gate;
  localparam int W = 16;
  localparam int N = 4;
  localparam logic [W-1:0] ALL1 = {W{1'b1}};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;   // 250 MHz

  logic         cyc_valid = 0, cyc_write = 0, pa_wr = 0, ds_wr = 0, ctl_reset = 0;
  logic [W-1:0] wr_data = '0;
  logic [N-1:0] match = '0;
  logic [N:0]   chain;
  logic [N:0]   hit;
  logic [N-1:0] wa, rd;

  assign chain[0] = 1'b1;
  assign hit[0]   = 1'b0;

  for (genvar g = 0; g < N; g++) begin : g_dev
    if (g == 0) begin : g_first
      chain_sel_gate #(.W(W)) u0 (
        .clk(clk), .rst_n(rst_n), .cyc_valid(cyc_valid), .cyc_write(cyc_write),
        .pa_wr(pa_wr), .ds_wr(ds_wr), .wr_data(wr_data), .ctl_reset(ctl_reset),
        .match_i(match[g]), .chain_en_i(chain[g]), .hit_i(hit[g]),
        .wr_accept_o(wa[g]), .rd_drive_o(rd[g]), .chain_en_o(chain[g+1]), .hit_o(hit[g+1]));
    end else begin : g_rest
      chain_sel_gate #(.W(W)) u_dev (
        .clk(clk), .rst_n(rst_n), .cyc_valid(cyc_valid), .cyc_write(cyc_write),
        .pa_wr(pa_wr), .ds_wr(ds_wr), .wr_data(wr_data), .ctl_reset(ctl_reset),
        .match_i(match[g]), .chain_en_i(chain[g]), .hit_i(hit[g]),
        .wr_accept_o(wa[g]), .rd_drive_o(rd[g]), .chain_en_o(chain[g+1]), .hit_o(hit[g+1]));
    end
  end

  // behavioural reference state
  logic [W-1:0] m_pa [N];
  logic [W-1:0] m_ds [N];
  logic         m_full [N];

  int checks = 0;
  int errors = 0;
  bit done = 0;

  task automatic chk(input string tag, input string what, input int dev, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s dev%0d actual=%b expected=%b", tag, what, dev, act, exp);
    end
  endtask

  task automatic compare(input string tag);
    logic cin, h, bc, own, ewa, erd;
    cin = 1'b1; h = 1'b0;
    for (int i = 0; i < N; i++) begin
      bc  = (m_ds[i] == ALL1);
      own = !bc && (m_ds[i] == m_pa[i]);
      ewa = cyc_valid && cyc_write && (bc || own);
      erd = cyc_valid && !cyc_write && ((bc && match[i] && !h) || own);
      chk(tag, "wr_accept", i, wa[i], ewa);
      chk(tag, "rd_drive", i, rd[i], erd);
      cin = cin && m_full[i];
      chk(tag, "chain_en", i, chain[i+1], cin);
      h = h || match[i];
      chk(tag, "hit", i, hit[i+1], h);
    end
  endtask

  task automatic update();
    logic cin;
    cin = 1'b1;
    for (int i = 0; i < N; i++) begin
      logic cnext;
      cnext = cin && m_full[i];
      if (ctl_reset) begin
        m_ds[i] = '0; m_full[i] = 1'b0;
      end else begin
        if (ds_wr) m_ds[i] = wr_data;
        if (pa_wr && cin && !m_full[i] && wr_data != ALL1) begin
          m_pa[i] = wr_data; m_full[i] = 1'b1;
        end
      end
      cin = cnext;
    end
  endtask

  // one bus clock: drive at negedge, compare, then advance the model at posedge
  task automatic cyc(input string tag, input logic v, input logic w, input logic pw,
                     input logic dw, input logic cr, input logic [W-1:0] d, input logic [N-1:0] m);
    @(negedge clk);
    cyc_valid = v; cyc_write = w; pa_wr = pw; ds_wr = dw; ctl_reset = cr; wr_data = d; match = m;
    #1;
    compare(tag);
    @(posedge clk);
    update();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #400000;
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    for (int i = 0; i < N; i++) begin
      m_pa[i] = '0; m_ds[i] = '0; m_full[i] = 1'b0;
    end
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1: reset state, DS == PA == 0 so each device is self-selected
    cyc("R1", 0, 0, 0, 0, 0, '0, '0);
    cyc("R1", 1, 1, 0, 0, 0, '0, '0);
    // R2 R4: load identifiers along the chain; R3: all-ones refused mid-way
    cyc("R2", 0, 0, 1, 0, 0, 16'h0011, '0);
    cyc("R4", 0, 0, 1, 0, 0, 16'h0022, '0);
    cyc("R3", 0, 0, 1, 0, 0, ALL1, '0);
    cyc("R3", 0, 0, 0, 0, 0, '0, '0);
    cyc("R2", 0, 0, 1, 0, 0, 16'h0033, '0);
    cyc("R2", 0, 0, 1, 0, 0, 16'h0044, '0);
    cyc("R4", 0, 0, 1, 0, 0, 16'h0055, '0);   // chain full, ignored
    // R5 R6: broadcast select
    cyc("R5", 0, 0, 0, 1, 0, ALL1, '0);
    cyc("R6", 1, 1, 0, 0, 0, '0, 4'b1111);
    cyc("R7", 1, 0, 0, 0, 0, '0, 4'b0000);
    cyc("R7", 1, 0, 0, 0, 0, '0, 4'b1010);
    cyc("R7", 1, 0, 0, 0, 0, '0, 4'b1001);
    cyc("R7", 1, 0, 0, 0, 0, '0, 4'b0100);
    cyc("R11", 0, 0, 0, 0, 0, '0, 4'b1111);
    // R8: address one device
    cyc("R5", 0, 0, 0, 1, 0, 16'h0022, '0);
    cyc("R8", 1, 1, 0, 0, 0, '0, '0);
    cyc("R8", 1, 0, 0, 0, 0, '0, 4'b0000);
    cyc("R8", 1, 0, 0, 0, 0, '0, 4'b1111);
    // R9: unknown select value
    cyc("R5", 0, 0, 0, 1, 0, 16'h0077, '0);
    cyc("R9", 1, 1, 0, 0, 0, '0, 4'b1111);
    cyc("R9", 1, 0, 0, 0, 0, '0, 4'b1111);
    // R10: soft reset colliding with a load and a select write
    cyc("R10", 0, 0, 1, 1, 1, 16'h0099, '0);
    cyc("R10", 1, 1, 0, 0, 0, '0, '0);
    for (int k = 0; k < N; k++) begin
      cyc("R10", 0, 0, 0, 1, 0, 16'h0011 * (k + 1), '0);
      cyc("R10", 1, 0, 0, 0, 0, '0, '0);
      cyc("R10", 1, 1, 0, 0, 0, '0, '0);
    end
    // R2 after soft reset: reloading works and re-chains
    cyc("R2", 0, 0, 1, 0, 0, 16'h0101, '0);
    cyc("R4", 0, 0, 0, 1, 0, 16'h0101, '0);
    cyc("R8", 1, 0, 0, 0, 0, '0, '0);
    cyc("R11", 0, 1, 0, 0, 0, '0, '0);
    finish_run();
  end

  // chain-level property: never two drivers on the shared bus
  always @(negedge clk) begin
    if (rst_n && !done) begin
      checks++;
      if ($countones(rd) > 1) begin
        errors++;
        $display("FAIL R7 bus contention actual=%b expected=at most one", rd);
      end
    end
  end
endmodule